// File: doc/BRIEF.md
# Four-Channel Sample Sequencer

This block chooses which of four analog inputs a shared converter samples next. A 9-bit control word sets the behaviour. In four-channel mode the block steps through the inputs on each conversion tick. The order is either A-B-C-D or D-C-B-A, and every sample-boundary pulse sends the sequence back to the first channel of the chosen order. In single-channel mode the block stays on one channel, which is named by a one-hot group of select bits.

A control write goes into a pending copy. The block moves it into the active copy only on a sample-boundary pulse, so a scan that has already started always finishes with the settings it began with. Power-down freezes the block: the sequence stops, the outputs hold their values, and writes and pulses are ignored, so the control word comes back unchanged. A sticky flag records any write that sets the reserved bits. A second flag reports a single-channel select group with no bit set, or with more than one.

Top module: `chan_seq_top`

## Requirements
- R1: After a synchronous reset, `ch_idx` is 0 (channel A), `ch_sel` is 4'b0001, and both flags are 0. The control word takes its default value: forward order, and single-channel select bit 3 (channel A) set.
- R2: In four-channel mode (`quad_mode`=1) with word bit 4 clear, each conversion tick moves `ch_idx` one step along 0,1,2,3 and then wraps back to 0. Channel codes are A=0, B=1, C=2, D=3. Outputs change one clock after the edge that samples the tick.
- R3: In four-channel mode with word bit 4 set, ticks move `ch_idx` along 3,2,1,0 and then wrap back to 3.
- R4: A sample-boundary pulse restarts the sequence at the first channel of the active order: 0 for forward, 3 for reversed. The outputs show it one clock after the edge that samples the pulse.
- R5: In single-channel mode (`quad_mode`=0), word bits 3, 2, 1 and 0 pick channel A, B, C and D. The selection does not move on ticks.
- R6: In single-channel mode, `illegal_cfg` is 1 when none or more than one of bits 3..0 is set. The lowest-lettered set channel is then used, and A is used when no bit is set. In four-channel mode `illegal_cfg` is 0.
- R7: An accepted write with any of bits 8..5 set makes `rsvd_err` 1, and it stays 1 until reset. Those bits are kept as zero and have no effect on the sequence.
- R8: A write changes nothing in the running sequence until the next sample-boundary pulse.
- R9: While `pwr_dn` is 1, `ch_idx`, `ch_sel` and `illegal_cfg` hold their values, and writes and pulses are ignored. The control word that was in use before power-down is still in use afterwards.
- R10: `ch_sel` is always one-hot, and `ch_sel[i]` is set exactly when `ch_idx` equals i (bit 0 is A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word: [8:5] reserved, [4] reverse order, [3:0] single-channel picks A..D |
| smp_pulse | input | 1 | Sample-boundary pulse; restarts the sequence and loads the pending word |
| conv_tick | input | 1 | Conversion tick; one pulse per converter clock rise |
| quad_mode | input | 1 | 1 selects four-channel scan, 0 selects single-channel |
| pwr_dn | input | 1 | Power-down; freezes all state |
| ch_sel | output | 4 | One-hot channel select, bit 0 = A |
| ch_idx | output | 2 | Selected channel code, A=0 to D=3 |
| illegal_cfg | output | 1 | Single-channel select group is not one-hot |
| rsvd_err | output | 1 | Sticky flag: a reserved bit was written as one |

## Verification
A vector table runs forward and reversed scans through a full wrap, which separates an off-by-one wrap from a correct one. It also runs each single-channel pick, to catch swapped bit-to-channel mapping, and select groups that are empty or have several bits set, to expose a wrong priority. Directed sequences then write in the middle of a scan and restart in the middle of a scan, showing that a write waits for the pulse and that the restart point follows the active order. Power-down is tested with ticks, a mode change, a reserved-bit write and a pulse applied while it is held, which shows whether any of them leaks into the state. Reset is tested last, checking both the reset outputs and the default word.

// File: rtl/chseq_pkg.sv
package chseq_pkg;

    localparam int NUM_CH   = 4;
    localparam int IDX_W    = $clog2(NUM_CH);
    localparam int WORD_W   = 9;
    localparam int REV_BIT  = NUM_CH;
    localparam int RSVD_LSB = REV_BIT + 1;

    typedef logic [IDX_W-1:0]  ch_idx_t;
    typedef logic [NUM_CH-1:0] ch_vec_t;

    // Stored control: reserved bits are never kept.
    typedef struct packed {
        logic    rev;
        ch_vec_t pick;   // pick[NUM_CH-1] is channel A
    } mux_ctl_t;

    typedef struct packed {
        ch_idx_t idx;
        logic    bad;
    } pick_res_t;

    localparam mux_ctl_t CTL_DEFAULT = '{rev: 1'b0, pick: {1'b1, {(NUM_CH-1){1'b0}}}};

    function automatic mux_ctl_t clean_word(input logic [WORD_W-1:0] w);
        mux_ctl_t c;
        c.rev  = w[REV_BIT];
        c.pick = w[NUM_CH-1:0];
        return c;
    endfunction

    function automatic logic has_rsvd(input logic [WORD_W-1:0] w);
        return |w[WORD_W-1:RSVD_LSB];
    endfunction

    function automatic ch_idx_t first_chan(input logic rev);
        return rev ? ch_idx_t'(NUM_CH-1) : '0;
    endfunction

    function automatic ch_idx_t order_map(input logic rev, input ch_idx_t pos);
        return rev ? ch_idx_t'(NUM_CH-1) - pos : pos;
    endfunction

    function automatic ch_idx_t next_pos(input ch_idx_t pos);
        return (pos == ch_idx_t'(NUM_CH-1)) ? '0 : pos + ch_idx_t'(1);
    endfunction

    // Lowest channel letter wins; no bit set yields channel A.
    function automatic pick_res_t pick_decode(input ch_vec_t pick);
        pick_res_t r;
        r.idx = '0;
        r.bad = ($countones(pick) != 1);
        for (int c = NUM_CH-1; c >= 0; c--) begin
            if (pick[NUM_CH-1-c]) r.idx = ch_idx_t'(c);
        end
        return r;
    endfunction

    function automatic ch_vec_t to_onehot(input ch_idx_t idx);
        return ch_vec_t'(1) << idx;
    endfunction

endpackage

// File: rtl/chseq_cfg.sv
module chseq_cfg
    import chseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    output logic              act_rev,
    output ch_vec_t           act_pick,
    output logic              rsvd_err
);

    mux_ctl_t pend_q;
    mux_ctl_t act_q;
    logic     rsvd_q;
    logic     accept;
    logic     take;

    assign accept = wr_en && !pwr_dn;
    assign take   = load && !pwr_dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= CTL_DEFAULT;
            act_q  <= CTL_DEFAULT;
            rsvd_q <= 1'b0;
        end else begin
            if (accept) begin
                pend_q <= clean_word(wr_data);
                if (has_rsvd(wr_data)) rsvd_q <= 1'b1;
            end
            if (take) act_q <= pend_q;
        end
    end

    assign act_rev  = act_q.rev;
    assign act_pick = act_q.pick;
    assign rsvd_err = rsvd_q;

    // R7
    rsvd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rsvd_err |=> rsvd_err);

    // R7
    rsvd_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !pwr_dn && (wr_data[WORD_W-1:RSVD_LSB] != '0)) |=> rsvd_err);

    // R9
    pd_ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> ($stable(act_rev) && $stable(act_pick)));

endmodule

// File: rtl/chseq_core.sv
module chseq_core
    import chseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    quad,
    input  logic    tick,
    input  logic    restart,
    output ch_idx_t pos
);

    ch_idx_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (run) begin
            if (restart)           pos_q <= '0;
            else if (tick && quad) pos_q <= next_pos(pos_q);
        end
    end

    assign pos = pos_q;

    // R2
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && quad && tick && !restart) |=>
            (pos == ch_idx_t'((int'($past(pos)) + 1) % NUM_CH)));

    // R4
    restart_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (run && restart) |=> (pos == '0));

endmodule

// File: rtl/chseq_out.sv
module chseq_out
    import chseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    quad,
    input  logic    rev,
    input  ch_vec_t pick,
    input  ch_idx_t pos,
    output ch_idx_t ch_idx,
    output ch_vec_t ch_sel,
    output logic    illegal
);

    pick_res_t res;
    ch_idx_t   nxt_idx;
    logic      nxt_bad;
    ch_idx_t   idx_q;
    ch_vec_t   sel_q;
    logic      bad_q;

    always_comb begin
        res = pick_decode(pick);
        if (quad) begin
            nxt_idx = order_map(rev, pos);
            nxt_bad = 1'b0;
        end else begin
            nxt_idx = res.idx;
            nxt_bad = res.bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            sel_q <= to_onehot('0);
            bad_q <= 1'b0;
        end else if (run) begin
            idx_q <= nxt_idx;
            sel_q <= to_onehot(nxt_idx);
            bad_q <= nxt_bad;
        end
    end

    assign ch_idx  = idx_q;
    assign ch_sel  = sel_q;
    assign illegal = bad_q;

    // R9
    pd_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(ch_idx) && $stable(ch_sel) && $stable(illegal)));

    // R6
    empty_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !quad && (pick == '0)) |=> (illegal && ch_idx == '0));

endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top
    import chseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [8:0] cfg_wdata,
    input  logic       smp_pulse,
    input  logic       conv_tick,
    input  logic       quad_mode,
    input  logic       pwr_dn,
    output logic [3:0] ch_sel,
    output logic [1:0] ch_idx,
    output logic       illegal_cfg,
    output logic       rsvd_err
);

    logic    run;
    logic    act_rev;
    ch_vec_t act_pick;
    ch_idx_t pos;

    assign run = !pwr_dn;

    chseq_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .pwr_dn   (pwr_dn),
        .wr_en    (cfg_we),
        .wr_data  (cfg_wdata),
        .load     (smp_pulse),
        .act_rev  (act_rev),
        .act_pick (act_pick),
        .rsvd_err (rsvd_err)
    );

    chseq_core u_core (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .quad    (quad_mode),
        .tick    (conv_tick),
        .restart (smp_pulse),
        .pos     (pos)
    );

    chseq_out u_out (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .quad    (quad_mode),
        .rev     (act_rev),
        .pick    (act_pick),
        .pos     (pos),
        .ch_idx  (ch_idx),
        .ch_sel  (ch_sel),
        .illegal (illegal_cfg)
    );

    // R10
    sel_match_chk: assert property (@(posedge clk) disable iff (rst)
        ($onehot(ch_sel) && ch_sel[ch_idx]));

    // R4
    restart_out_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_pulse && !pwr_dn) ##1 (!pwr_dn && quad_mode && !smp_pulse) |=>
            (ch_idx == first_chan(act_rev)));

    // R6
    quad_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (quad_mode && !pwr_dn) |=> !illegal_cfg);

endmodule

// File: tb/chan_seq_top_bench.sv
`timescale 1ns/1ps
module chan_seq_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic       smp_pulse = 1'b0;
    logic       conv_tick = 1'b0;
    logic       quad_mode = 1'b1;
    logic       pwr_dn = 1'b0;
    logic [3:0] ch_sel;
    logic [1:0] ch_idx;
    logic       illegal_cfg;
    logic       rsvd_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    chan_seq_top u_chan_seq_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .smp_pulse(smp_pulse), .conv_tick(conv_tick), .quad_mode(quad_mode),
        .pwr_dn(pwr_dn), .ch_sel(ch_sel), .ch_idx(ch_idx),
        .illegal_cfg(illegal_cfg), .rsvd_err(rsvd_err)
    );

    typedef struct packed {
        logic       quad;
        logic [8:0] word;
        logic [1:0] e0, e1, e2, e3, e4;
        logic       bad;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 9'h000, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 1'b0},  // R2 forward
        '{1'b1, 9'h010, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 1'b0},  // R3 reversed
        '{1'b0, 9'h004, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 1'b0},  // R5 B
        '{1'b0, 9'h001, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 1'b0},  // R5 D
        '{1'b0, 9'h002, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 1'b0},  // R5 C
        '{1'b0, 9'h00C, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1},  // R6 A+B
        '{1'b0, 9'h000, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1},  // R6 none
        '{1'b0, 9'h003, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 1'b1},  // R6 C+D
        '{1'b1, 9'h01F, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 1'b0}   // R3 R6 quad ignores picks
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_ch(input string tag, input int exp);
        chk({tag, " idx"}, int'(ch_idx), exp);
        chk({tag, " sel R10"}, int'(ch_sel), 1 << exp);
    endtask

    task automatic wr(input logic [8:0] d);
        cfg_we = 1'b1; cfg_wdata = d; step();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse();
        smp_pulse = 1'b1; step(); smp_pulse = 1'b0; step();
    endtask

    task automatic tick();
        conv_tick = 1'b1; step(); conv_tick = 1'b0; step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        step(); step(); rst = 1'b0; step();
        // R1 reset state
        chk_ch("R1 reset", 0);
        chk("R1 illegal", int'(illegal_cfg), 0);
        chk("R1 rsvd", int'(rsvd_err), 0);

        // R2 R3 R5 R6 table
        foreach (VECS[i]) begin
            quad_mode = VECS[i].quad;
            wr(VECS[i].word);
            pulse();
            chk_ch($sformatf("R4 vec%0d start", i), int'(VECS[i].e0));
            chk($sformatf("R6 vec%0d illegal", i), int'(illegal_cfg), int'(VECS[i].bad));
            tick(); chk_ch($sformatf("R2/R3/R5 vec%0d t1", i), int'(VECS[i].e1));
            tick(); chk_ch($sformatf("R2/R3/R5 vec%0d t2", i), int'(VECS[i].e2));
            tick(); chk_ch($sformatf("R2/R3/R5 vec%0d t3", i), int'(VECS[i].e3));
            tick(); chk_ch($sformatf("R2/R3/R5 vec%0d wrap", i), int'(VECS[i].e4));
        end
        chk("R7 no reserved yet", int'(rsvd_err), 0);

        // R8 write mid-scan waits for pulse
        quad_mode = 1'b1;
        wr(9'h000); pulse(); chk_ch("R8 fwd start", 0);
        tick(); chk_ch("R8 step", 1);
        wr(9'h010); step(); chk_ch("R8 after write", 1);
        tick(); chk_ch("R8 still forward", 2);
        pulse(); chk_ch("R8 reversed at pulse", 3);

        // R4 restart mid-scan
        tick(); tick(); chk_ch("R4 mid", 1);
        pulse(); chk_ch("R4 restart reversed", 3);
        tick(); chk_ch("R4 pre-pd", 2);

        // R9 power-down
        pwr_dn = 1'b1; step();
        tick(); chk_ch("R9 tick ignored", 2);
        quad_mode = 1'b0; step(); chk_ch("R9 mode change held", 2);
        chk("R9 illegal held", int'(illegal_cfg), 0);
        wr(9'h100); pulse(); chk_ch("R9 pulse ignored", 2);
        chk("R9 reserved write ignored", int'(rsvd_err), 0);
        quad_mode = 1'b1; pwr_dn = 1'b0; step(); chk_ch("R9 resume", 2);
        pulse(); chk_ch("R9 word retained", 3);

        // R7 reserved bits
        wr(9'h1E4); chk("R7 flag set", int'(rsvd_err), 1);
        quad_mode = 1'b0; pulse(); chk_ch("R7 bits dropped", 1);
        chk("R7 clean pick legal", int'(illegal_cfg), 0);
        wr(9'h008); step(); chk("R7 sticky", int'(rsvd_err), 1);
        quad_mode = 1'b1; pulse(); chk_ch("R7 forward", 0);
        tick(); tick(); chk_ch("R7 pre-reset", 2);

        // R1 reset mid-operation and default word
        rst = 1'b1; step(); rst = 1'b0;
        chk_ch("R1 reset again", 0);
        chk("R1 rsvd cleared", int'(rsvd_err), 0);
        chk("R1 illegal cleared", int'(illegal_cfg), 0);
        quad_mode = 1'b0; pulse(); chk_ch("R1 default pick A", 0);
        chk("R1 default legal", int'(illegal_cfg), 0);
        quad_mode = 1'b1; tick(); chk_ch("R1 default forward", 1);

        summary();
        $finish;
    end

endmodule